// File: doc/BRIEF.md
# PIO Packet-Command Read Sequencer

This block is the device-side sequencer for a storage packet command that runs in programmed I/O. The host first programs a transfer byte-count limit and a DMA request flag. It then issues the packet command and writes a 12-byte command packet as six 16-bit words through the data port. When the packet holds a ten-byte-form read request, the block streams the requested 2048-byte blocks back through the same data port. It pulls each word from an external word-stream source model.

The data is split into chunks. Each chunk holds the host limit (rounded down to an even value) or the bytes still outstanding, whichever is smaller. Every chunk is announced by an interrupt with the data-request status bit set, and the chunk size is reported in the byte-count registers. A short busy window separates two chunks. After the final word the block raises one more interrupt and returns to ready with the data request cleared. A read of the status register acknowledges the interrupt.

Top module: `atapi_pio_seq`

## Requirements
- R1: After reset, status (address 7) reads 0x40, the interrupt reason (address 2) reads 0, the byte-count low register (address 4) reads 0, and `irq` is low.
- R2: Writing 0xA0 to address 7 while ready starts a packet command. The limit is latched from addresses 4 (low byte) and 5 (high byte), and bit 0 of address 1 is latched onto `pkt_dma`. Status then reads 0x48 (bit 3 data request, bit 6 ready) and the interrupt reason reads 1 (bit 0 command, bit 1 device-to-host).
- R3: The six packet words are written to address 0, with byte 2i in the low half of word i. Opcode 0x28 in byte 0 selects a read. Bytes 2..5 hold the block address, most significant byte first, and bytes 7..8 hold the block count, most significant byte first. Data word k comes from source address block_address*1024+k.
- R4: Each chunk holds min(E, remaining bytes), where E is the latched limit with bit 0 cleared, or 2 when that value is 0. While the chunk is offered, the chunk size can be read from addresses 4 and 5.
- R5: Before each chunk, `irq` rises, status reads 0x48 and the interrupt reason reads 2.
- R6: After the last word of a non-final chunk, status reads 0xC0 (bit 7 busy) for one cycle. If status is read in that cycle, the next chunk's interrupt is still raised.
- R7: After the last word of the transfer, `irq` rises, status reads 0x40 and the interrupt reason reads 3.
- R8: Reading status at address 7 clears `irq`, unless the interrupt is raised in that same cycle.
- R9: A block count of 0, or an opcode other than 0x28, skips the data phase and goes straight to the completion interrupt of R7.
- R10: While the block is not ready, writes to addresses 1, 4, 5 and 7 are ignored. Writes of values other than 0xA0 to address 7 are ignored. Data-port writes outside the packet phase are ignored.
- R11: `src_take` is high exactly while address 0 is read during a data chunk. At that time `src_addr` holds the word being returned, and it advances by one after each take. A data-port read outside a chunk returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (read side effects occur at the edge) |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, combinational from address |
| irq | output | 1 | Interrupt request to host |
| pkt_dma | output | 1 | DMA request flag latched at the packet command |
| src_addr | output | ADDR_W | Word address presented to the source model |
| src_take | output | 1 | Source word consumed this cycle |
| src_word | input | 16 | Word returned by the source model for `src_addr` |

## Verification
Two events can fall in the same cycle: the acknowledge of an interrupt by a status read, and the raising of the next chunk's interrupt. This happens when the host polls status during the one-cycle busy window that follows a non-final chunk. The bench provokes it by reading status right after the last word of each chunk in selected transfers. It expects that read to return the busy value, and expects `irq` to be high on the following cycle. Transfers with odd, tiny, zero and large limits then check that every chunk size, word value and final state match figures computed from the block count and limit.

// File: rtl/atapi_seq_pkg.sv
// Package: shared constants and state type for the packet-command read sequencer.
// Assumes a fixed 12-byte command packet carrying a 32-bit block address and
// a 16-bit block count, and a 16-bit byte-count limit.
package atapi_seq_pkg;
    localparam int LBA_W = 32;
    localparam int CNT_W = 16;
    localparam int LIM_W = 16;
    localparam int PKT_WORDS = 6;

    localparam logic [2:0] A_DATA = 3'd0;
    localparam logic [2:0] A_FEAT = 3'd1;
    localparam logic [2:0] A_IRS  = 3'd2;
    localparam logic [2:0] A_BCLO = 3'd4;
    localparam logic [2:0] A_BCHI = 3'd5;
    localparam logic [2:0] A_CMD  = 3'd7;

    localparam logic [7:0] CMD_PACKET = 8'hA0;
    localparam logic [7:0] OP_READ10  = 8'h28;

    localparam logic [1:0] IRS_CMD     = 2'd1;
    localparam logic [1:0] IRS_DATA_IN = 2'd2;
    localparam logic [1:0] IRS_DONE    = 2'd3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PKT,
        S_SETUP,
        S_ARM,
        S_DATA
    } seq_state_t;
endpackage

// File: rtl/atapi_pkt_decoder.sv
// Module: captures the command-packet words that matter and decodes them.
// Word i carries packet byte 2i in its low half. Only the opcode, the
// big-endian block address and the big-endian block count are kept; every
// kept field is rewritten by each new packet, so no clear is needed.
module atapi_pkt_decoder
    import atapi_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_we,
    input  logic [2:0]       word_idx,
    input  logic [15:0]      word_in,
    output logic             op_read10,
    output logic [LBA_W-1:0] lba,
    output logic [CNT_W-1:0] blk_cnt
);
    logic [7:0]       op_q;
    logic [LBA_W-1:0] lba_q;
    logic [CNT_W-1:0] cnt_q;

    // Store the packet bytes that carry the opcode, address and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= '0;
            lba_q <= '0;
            cnt_q <= '0;
        end else if (word_we) begin
            case (word_idx)
                3'd0: op_q          <= word_in[7:0];
                3'd1: lba_q[31:16]  <= {word_in[7:0], word_in[15:8]};
                3'd2: lba_q[15:0]   <= {word_in[7:0], word_in[15:8]};
                3'd3: cnt_q[15:8]   <= word_in[15:8];
                3'd4: cnt_q[7:0]    <= word_in[7:0];
                default: ;
            endcase
        end
    end

    // Present the decoded request.
    always_comb begin
        op_read10 = (op_q == OP_READ10);
        lba       = lba_q;
        blk_cnt   = cnt_q;
    end
endmodule

// File: rtl/atapi_chunk_sizer.sv
// Module: computes the size of the next data chunk in bytes.
// The host limit loses bit 0; a result of zero is raised to 2 so the
// transfer always makes progress. Assumes remaining is even.
module atapi_chunk_sizer
    import atapi_seq_pkg::*;
#(
    parameter int REM_W = 27
) (
    input  logic [LIM_W-1:0] limit,
    input  logic [REM_W-1:0] remaining,
    output logic [LIM_W-1:0] chunk_bytes
);
    logic [LIM_W-1:0] eff;

    // Round the limit down to even and pick the smaller of limit and remainder.
    always_comb begin
        eff = {limit[LIM_W-1:1], 1'b0};
        if (eff == '0) eff = LIM_W'(2);
        if (remaining < REM_W'(eff)) chunk_bytes = remaining[LIM_W-1:0];
        else                         chunk_bytes = eff;
    end
endmodule

// File: rtl/atapi_xfer_fsm.sv
// Module: phase sequencer for the packet command: packet intake, setup,
// per-chunk arming with interrupt, word streaming and completion.
// Assumes one host access per cycle; a status read and an interrupt raise in
// the same cycle leave the interrupt pending.
module atapi_xfer_fsm
    import atapi_seq_pkg::*;
#(
    parameter int BLK_SH = 11,
    parameter int REM_W  = CNT_W + BLK_SH,
    parameter int ADDR_W = LBA_W + BLK_SH - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic              status_rd,
    input  logic              op_read10,
    input  logic [LBA_W-1:0]  lba,
    input  logic [CNT_W-1:0]  blk_cnt,
    input  logic [LIM_W-1:0]  chunk_bytes,
    output logic [2:0]        word_idx,
    output logic              word_we,
    output logic [REM_W-1:0]  rem_bytes,
    output logic              bc_load,
    output logic              st_bsy,
    output logic              st_drq,
    output logic              in_data,
    output logic              irq,
    output logic [1:0]        ireason,
    output logic [ADDR_W-1:0] src_addr,
    output logic              src_take
);
    seq_state_t        state;
    logic [2:0]        widx_q;
    logic [REM_W-1:0]  rem_q;
    logic [LIM_W-2:0]  left_q;
    logic [ADDR_W-1:0] addr_q;
    logic              irq_q;
    logic [1:0]        irs_q;
    logic              go_acc;
    logic              last_word;
    logic              irq_set;

    // Decode accepted events of the current cycle.
    always_comb begin
        go_acc    = go && (state == S_IDLE);
        last_word = (state == S_DATA) && data_rd && (left_q == (LIM_W-1)'(1));
        irq_set   = ((state == S_ARM)) || (last_word && (rem_q == REM_W'(2)));
    end

    // Sequence the phases and track chunk and transfer progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            widx_q <= '0;
            rem_q  <= '0;
            left_q <= '0;
            addr_q <= '0;
            irs_q  <= '0;
        end else begin
            case (state)
                S_IDLE: if (go_acc) begin
                    state  <= S_PKT;
                    widx_q <= '0;
                    irs_q  <= IRS_CMD;
                end
                S_PKT: if (data_wr) begin
                    widx_q <= widx_q + 3'd1;
                    if (widx_q == 3'(PKT_WORDS - 1)) state <= S_SETUP;
                end
                S_SETUP: begin
                    rem_q  <= op_read10 ? {blk_cnt, {BLK_SH{1'b0}}} : '0;
                    addr_q <= {lba, {(BLK_SH-1){1'b0}}};
                    state  <= S_ARM;
                end
                S_ARM: begin
                    if (rem_q == '0) begin
                        state <= S_IDLE;
                        irs_q <= IRS_DONE;
                    end else begin
                        left_q <= chunk_bytes[LIM_W-1:1];
                        irs_q  <= IRS_DATA_IN;
                        state  <= S_DATA;
                    end
                end
                S_DATA: if (data_rd) begin
                    addr_q <= addr_q + ADDR_W'(1);
                    rem_q  <= rem_q - REM_W'(2);
                    left_q <= left_q - (LIM_W-1)'(1);
                    if (last_word) begin
                        if (rem_q == REM_W'(2)) begin
                            state <= S_IDLE;
                            irs_q <= IRS_DONE;
                        end else begin
                            state <= S_ARM;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Hold the interrupt until a status read, letting a new raise win.
    always_ff @(posedge clk) begin
        if (!rst_n)      irq_q <= 1'b0;
        else if (go_acc) irq_q <= 1'b0;
        else             irq_q <= irq_set || (irq_q && !status_rd);
    end

    // Drive status flags and source handshake.
    always_comb begin
        word_idx  = widx_q;
        word_we   = (state == S_PKT) && data_wr;
        rem_bytes = rem_q;
        bc_load   = (state == S_ARM) && (rem_q != '0);
        st_bsy    = (state == S_SETUP) || (state == S_ARM);
        st_drq    = (state == S_PKT) || (state == S_DATA);
        in_data   = (state == S_DATA);
        irq       = irq_q;
        ireason   = irs_q;
        src_addr  = addr_q;
        src_take  = (state == S_DATA) && data_rd;
    end
endmodule

// File: rtl/atapi_pio_seq.sv
// Module: top of the packet-command read sequencer. Holds the host-visible
// registers (feature flag, byte-count pair, latched limit), the read mux and
// the status byte, and ties the decoder, sizer and phase sequencer together.
// Assumes one host access per cycle; read side effects act at the clock edge.
module atapi_pio_seq
    import atapi_seq_pkg::*;
#(
    parameter int BLK_BYTES = 2048,
    localparam int BLK_SH   = $clog2(BLK_BYTES),
    localparam int REM_W    = CNT_W + BLK_SH,
    localparam int ADDR_W   = LBA_W + BLK_SH - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [2:0]        host_addr,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    output logic              irq,
    output logic              pkt_dma,
    output logic [ADDR_W-1:0] src_addr,
    output logic              src_take,
    input  logic [15:0]       src_word
);
    logic             feat_dma_q;
    logic             pkt_dma_q;
    logic [LIM_W-1:0] bc_q;
    logic [LIM_W-1:0] lim_q;
    logic             go, data_wr, data_rd, status_rd, ready;
    logic             op_read10;
    logic [LBA_W-1:0] lba;
    logic [CNT_W-1:0] blk_cnt;
    logic [LIM_W-1:0] chunk_bytes;
    logic [2:0]       word_idx;
    logic             word_we;
    logic [REM_W-1:0] rem_bytes;
    logic             bc_load, st_bsy, st_drq, in_data;
    logic [1:0]       irs;
    logic [7:0]       status_b;

    // Decode host strobes by address.
    always_comb begin
        ready     = !st_bsy && !st_drq;
        go        = host_wr && (host_addr == A_CMD) && (host_wdata[7:0] == CMD_PACKET);
        data_wr   = host_wr && (host_addr == A_DATA);
        data_rd   = host_rd && (host_addr == A_DATA);
        status_rd = host_rd && (host_addr == A_CMD);
        status_b  = {st_bsy, 1'b1, 1'b0, 1'b0, st_drq, 3'b000};
    end

    // Host register writes, chunk-size report and command-time latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            feat_dma_q <= 1'b0;
            pkt_dma_q  <= 1'b0;
            bc_q       <= '0;
            lim_q      <= '0;
        end else begin
            if (bc_load) begin
                bc_q <= chunk_bytes;
            end else if (ready && host_wr && host_addr == A_BCLO) begin
                bc_q[7:0] <= host_wdata[7:0];
            end else if (ready && host_wr && host_addr == A_BCHI) begin
                bc_q[15:8] <= host_wdata[7:0];
            end
            if (ready && host_wr && host_addr == A_FEAT) feat_dma_q <= host_wdata[0];
            if (ready && go) begin
                lim_q     <= bc_q;
                pkt_dma_q <= feat_dma_q;
            end
        end
    end

    // Host read mux.
    always_comb begin
        case (host_addr)
            A_DATA:  host_rdata = in_data ? src_word : 16'h0000;
            A_IRS:   host_rdata = {14'b0, irs};
            A_BCLO:  host_rdata = {8'b0, bc_q[7:0]};
            A_BCHI:  host_rdata = {8'b0, bc_q[15:8]};
            A_CMD:   host_rdata = {8'b0, status_b};
            default: host_rdata = 16'h0000;
        endcase
    end

    assign pkt_dma = pkt_dma_q;

    atapi_pkt_decoder u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_we   (word_we),
        .word_idx  (word_idx),
        .word_in   (host_wdata),
        .op_read10 (op_read10),
        .lba       (lba),
        .blk_cnt   (blk_cnt)
    );

    atapi_chunk_sizer #(.REM_W(REM_W)) u_size (
        .limit       (lim_q),
        .remaining   (rem_bytes),
        .chunk_bytes (chunk_bytes)
    );

    atapi_xfer_fsm #(.BLK_SH(BLK_SH), .REM_W(REM_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (go),
        .data_wr     (data_wr),
        .data_rd     (data_rd),
        .status_rd   (status_rd),
        .op_read10   (op_read10),
        .lba         (lba),
        .blk_cnt     (blk_cnt),
        .chunk_bytes (chunk_bytes),
        .word_idx    (word_idx),
        .word_we     (word_we),
        .rem_bytes   (rem_bytes),
        .bc_load     (bc_load),
        .st_bsy      (st_bsy),
        .st_drq      (st_drq),
        .in_data     (in_data),
        .irq         (irq),
        .ireason     (irs),
        .src_addr    (src_addr),
        .src_take    (src_take)
    );
endmodule

// File: rtl/atapi_seq_checker.sv
// Module: temporal properties of the packet-command read sequencer, bound
// to the top module. Observes host strobes, status byte, reason, byte-count
// register, interrupt and source handshake.
module atapi_seq_checker #(
    parameter int ADDR_W = 42
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_rd,
    input logic              host_wr,
    input logic [2:0]        host_addr,
    input logic [15:0]       host_wdata,
    input logic              irq,
    input logic [7:0]        status_b,
    input logic [1:0]        ireason,
    input logic [15:0]       bc,
    input logic              src_take,
    input logic [ADDR_W-1:0] src_addr
);
    p_pkt_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 3'd7 && host_wdata[7:0] == 8'hA0 && status_b == 8'h40)
        |=> (status_b == 8'h48 && ireason == 2'd1));

    p_bc_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ireason == 2'd2 && status_b[3]) |-> (bc[0] == 1'b0 && bc != 16'd0));

    p_chunk_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_b[3] && $past(status_b[7])) |-> irq);

    p_drq_bsy_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_b[7] && status_b[3]));

    p_done_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ireason == 2'd3) |-> (status_b == 8'h40));

    p_irq_clr_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && host_addr == 3'd7 && status_b == 8'h40) |=> !irq);

    p_take_drq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        src_take |-> (status_b[3] && ireason == 2'd2));

    p_addr_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        src_take |=> (src_addr == $past(src_addr) + ADDR_W'(1)));
endmodule

bind atapi_pio_seq atapi_seq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .irq        (irq),
    .status_b   (status_b),
    .ireason    (irs),
    .bc         (bc_q),
    .src_take   (src_take),
    .src_addr   (src_addr)
);

// File: tb/tb_atapi_pio_seq.sv
module tb_atapi_pio_seq;
    localparam int ADDR_W = 42;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_wr = 1'b0;
    logic              host_rd = 1'b0;
    logic [2:0]        host_addr = 3'd0;
    logic [15:0]       host_wdata = 16'h0;
    logic [15:0]       host_rdata;
    logic              irq;
    logic              pkt_dma;
    logic [ADDR_W-1:0] src_addr;
    logic              src_take;
    logic [15:0]       src_word;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    function automatic logic [15:0] src_fn(input logic [ADDR_W-1:0] a);
        return a[15:0] ^ a[31:16] ^ {6'b0, a[41:32]} ^ 16'h3C5A;
    endfunction

    assign src_word = src_fn(src_addr);

    atapi_pio_seq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .irq        (irq),
        .pkt_dma    (pkt_dma),
        .src_addr   (src_addr),
        .src_take   (src_take),
        .src_word   (src_word)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wait_irq(input string tag);
        for (int i = 0; i < 16 && !irq; i++) @(negedge clk);
        chk(irq == 1'b1, tag, irq, 1);
    endtask

    task automatic xfer(input logic [7:0] op, input logic [31:0] lba, input int blocks,
                        input logic [15:0] lim, input logic dma, input bit poll, input bit meddle);
        logic [15:0] d, d2;
        int rem, eff, chunk, bad, badtake;
        bit first;
        logic [ADDR_W-1:0] wa;
        bus_wr(3'd1, {15'b0, dma});
        bus_wr(3'd4, {8'b0, lim[7:0]});
        bus_wr(3'd5, {8'b0, lim[15:8]});
        bus_wr(3'd7, 16'h00A0);
        chk(pkt_dma == dma, "R2 dma flag", pkt_dma, dma);
        bus_rd(3'd7, d); chk(d == 16'h48, "R2 packet status", d, 16'h48);
        bus_rd(3'd2, d); chk(d == 16'h1, "R2 packet reason", d, 1);
        bus_wr(3'd0, {8'h00, op});
        bus_wr(3'd0, {lba[23:16], lba[31:24]});
        bus_wr(3'd0, {lba[7:0], lba[15:8]});
        bus_wr(3'd0, {blocks[15:8], 8'h00});
        bus_wr(3'd0, {8'h00, blocks[7:0]});
        bus_wr(3'd0, 16'h0000);
        rem = (op == 8'h28) ? blocks * 2048 : 0;
        eff = int'(lim) & ~1;
        if (eff == 0) eff = 2;
        wa = {10'b0, lba} << 10;
        bad = 0; badtake = 0; first = 1'b1;
        while (1) begin
            wait_irq("R5 chunk or R7 final irq");
            if (rem == 0) break;
            bus_rd(3'd7, d); chk(d == 16'h48, "R5 chunk status", d, 16'h48);
            chk(irq == 1'b0, "R8 irq cleared", irq, 0);
            chunk = (rem < eff) ? rem : eff;
            bus_rd(3'd4, d); bus_rd(3'd5, d2);
            chk({d2[7:0], d[7:0]} == 16'(chunk), "R4 chunk size", {d2[7:0], d[7:0]}, chunk);
            bus_rd(3'd2, d); chk(d == 16'h2, "R5 data reason", d, 2);
            if (meddle && first) begin
                bus_wr(3'd7, 16'h00A0);
                bus_wr(3'd4, 16'h00FF);
                bus_wr(3'd5, 16'h00FF);
                bus_wr(3'd1, 16'h0000);
                bus_wr(3'd0, 16'h1234);
                bus_rd(3'd7, d); chk(d == 16'h48, "R10 status unchanged", d, 16'h48);
                bus_rd(3'd4, d); bus_rd(3'd5, d2);
                chk({d2[7:0], d[7:0]} == 16'(chunk), "R10 count unchanged", {d2[7:0], d[7:0]}, chunk);
                chk(pkt_dma == dma, "R10 dma flag unchanged", pkt_dma, dma);
            end
            for (int i = 0; i < chunk / 2; i++) begin
                host_rd = 1'b1; host_addr = 3'd0;
                #1;
                if (host_rdata != src_fn(wa)) begin
                    if (bad == 0) $display("  first word mismatch at %0h: %0h vs %0h", wa, host_rdata, src_fn(wa));
                    bad++;
                end
                if (!src_take || src_addr != wa) badtake++;
                @(negedge clk);
                host_rd = 1'b0;
                wa = wa + 1'b1;
            end
            rem = rem - chunk;
            first = 1'b0;
            if (poll && rem > 0) begin
                bus_rd(3'd7, d); chk(d == 16'hC0, "R6 busy between chunks", d, 16'hC0);
                chk(irq == 1'b1, "R6 raise wins over status read", irq, 1);
            end
        end
        bus_rd(3'd7, d); chk(d == 16'h40, "R7 final status", d, 16'h40);
        chk(irq == 1'b0, "R8 final irq cleared", irq, 0);
        bus_rd(3'd2, d); chk(d == 16'h3, "R7 final reason", d, 3);
        chk(bad == 0, "R3 data words", bad, 0);
        chk(badtake == 0, "R11 source handshake", badtake, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(irq == 1'b0, "R1 irq", irq, 0);
        bus_rd(3'd7, d); chk(d == 16'h40, "R1 status", d, 16'h40);
        bus_rd(3'd2, d); chk(d == 16'h0, "R1 reason", d, 0);
        bus_rd(3'd4, d); chk(d == 16'h0, "R1 count", d, 0);
        // R10 foreign command and stray data writes while ready
        bus_wr(3'd7, 16'h0020);
        bus_wr(3'd0, 16'h5555);
        bus_rd(3'd7, d); chk(d == 16'h40, "R10 foreign command", d, 16'h40);
        bus_rd(3'd2, d); chk(d == 16'h0, "R10 reason kept", d, 0);
        chk(irq == 1'b0, "R10 no irq", irq, 0);
        // R11 data-port read outside a chunk
        host_rd = 1'b1; host_addr = 3'd0;
        #1;
        chk(host_rdata == 16'h0, "R11 idle data read", host_rdata, 0);
        chk(src_take == 1'b0, "R11 idle take", src_take, 0);
        @(negedge clk);
        host_rd = 1'b0;
        // Sweep of transfers
        xfer(8'h28, 32'h0,        1, 16'd5120, 1'b0, 1'b0, 1'b0);
        xfer(8'h28, 32'h7,        3, 16'd5121, 1'b1, 1'b1, 1'b1);
        xfer(8'h28, 32'h00012345, 2, 16'd1000, 1'b0, 1'b1, 1'b0);
        xfer(8'h28, 32'hFFFFFFFF, 1, 16'd3,    1'b0, 1'b0, 1'b0);
        xfer(8'h28, 32'h10,       1, 16'd0,    1'b0, 1'b1, 1'b0);
        xfer(8'h28, 32'h5,        0, 16'd512,  1'b1, 1'b0, 1'b0); // R9 zero count
        xfer(8'h12, 32'h5,        2, 16'd512,  1'b0, 1'b0, 1'b0); // R9 other opcode
        xfer(8'h28, 32'h20,       2, 16'd4096, 1'b0, 1'b1, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule